// File: doc/BRIEF.md
# Multi-Mode Microcycle Clock Generator

This block derives the processor microcycle clock from a faster base clock. It counts base periods to shape each microcycle. With no requests pending, the clock is high for two base periods and low for two. Request inputs reshape individual microcycles:

- A stretch request adds one base period to the high phase.
- A hold request parks the clock in the high state until a bus reply or a DMA release frees it.
- A relocation request lengthens the low phase to five periods and fires a one-period address-capture strobe part way through it.
- An initialisation request lengthens the low phase to three periods.

All request inputs are sampled on the base clock at fixed points of the microcycle. The block drives only the microcycle clock and the capture strobe. The bus side and the relocation unit live elsewhere. A stopped microcycle is released a fixed number of base periods after the freeing event is captured. A bus reply takes three periods, which is close to 200 ns at a 65 ns base period. A DMA release takes two periods.

Top module: `microcycle_clkgen`

## Requirements
- R1: With no requests, `mclk` is high for exactly 2 base periods and low for exactly 2. During reset `mclk` is 1 and `addr_strobe` is 0.
- R2: `stretch_req` is sampled at the edge that ends the second high period. When it is 1 and `hold_req` is 0, the high phase lasts 3 base periods.
- R3: `hold_req` is sampled at the edge that ends the second high period. When it is 1, `mclk` stays high until a release, whatever `stretch_req` is.
- R4: A `reply_evt` captured at edge E while the clock is held makes `mclk` fall at edge E+4. The hold clears at E+3 and the fall comes one edge later.
- R5: A `dma_rel_evt` captured at edge E while the clock is held makes `mclk` fall at edge E+3.
- R6: `reply_evt` and `dma_rel_evt` are ignored outside the held state. They are also ignored once a release countdown has started. Ignored events do not change the microcycle length.
- R7: `reloc_req` is sampled at the edge where `mclk` falls. When it is 1, the low phase lasts 5 base periods.
- R8: In a relocation microcycle, `addr_strobe` is 1 for exactly one base period, the 4th base period of the low phase. It begins 3 edges after the fall. In any other microcycle it stays 0.
- R9: `init_req` is sampled one edge after `mclk` falls. When it is 1 and no relocation is in progress, the low phase lasts 3 base periods.
- R10: When relocation and initialisation are both requested, the low phase lasts 5 base periods and the strobe fires as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (one base period per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_req | input | 1 | Lengthen the high phase by one period |
| hold_req | input | 1 | Stop the clock in the high state |
| reloc_req | input | 1 | Relocation microcycle: long low phase and capture strobe |
| init_req | input | 1 | Initialisation microcycle: low phase of 3 periods |
| reply_evt | input | 1 | Bus reply received; releases a held clock |
| dma_rel_evt | input | 1 | DMA master returned the bus; releases a held clock |
| mclk | output | 1 | Microcycle clock |
| addr_strobe | output | 1 | One-period strobe that captures the relocated address |

## Verification
The hardest situation to reach is the held state with a release event arriving at a precise moment. The event must arrive neither too early, while the clock is still in its normal high phase, nor during a countdown that is already running. The stimulus locks onto every rising edge of `mclk` and counts high samples. It pulses the chosen event once in the first high period, where the event must be ignored. It then asserts the event across the third and fourth periods, so the first capture starts the countdown and the second must be ignored. A sweep over every combination of the four requests and both event types then checks the high length, low length and strobe position against lengths computed from the requirements.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_STOP = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mcg_release_timer.sv
module mcg_release_timer #(
    parameter int REPLY_DLY = 3,
    parameter int DMA_DLY   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic reply_evt,
    input  logic dma_rel_evt,
    output logic done
);
    localparam int DW = $clog2(mcg_pkg::max3(REPLY_DLY, DMA_DLY, 1) + 1);

    typedef struct packed {
        logic [DW-1:0] dly;
        logic          done;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.dly != '0) begin
            if (q.dly == DW'(1)) begin
                d.dly  = '0;
                d.done = 1'b1;
            end else begin
                d.dly = q.dly - DW'(1);
            end
        end else if (armed && !q.done) begin
            // a reply wins if both events come together
            if (reply_evt) begin
                d.dly = DW'(REPLY_DLY);
            end else if (dma_rel_evt) begin
                d.dly = DW'(DMA_DLY);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
endmodule

// File: rtl/mcg_low_shape.sv
module mcg_low_shape #(
    parameter int LO_CYC       = 2,
    parameter int INIT_LO_CYC  = 3,
    parameter int RELOC_LO_CYC = 5,
    parameter int CNT_W        = 3
) (
    input  logic             reloc,
    input  logic             init,
    output logic [CNT_W-1:0] last_idx
);
    always_comb begin
        if (reloc) begin
            last_idx = CNT_W'(RELOC_LO_CYC - 1);
        end else if (init) begin
            last_idx = CNT_W'(INIT_LO_CYC - 1);
        end else begin
            last_idx = CNT_W'(LO_CYC - 1);
        end
    end
endmodule

// File: rtl/microcycle_clkgen.sv
module microcycle_clkgen #(
    parameter int HI_CYC       = 2,
    parameter int STUT_CYC     = 3,
    parameter int LO_CYC       = 2,
    parameter int INIT_LO_CYC  = 3,
    parameter int RELOC_LO_CYC = 5,
    parameter int STROBE_IDX   = 3,
    parameter int REPLY_DLY    = 3,
    parameter int DMA_DLY      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_req,
    input  logic hold_req,
    input  logic reloc_req,
    input  logic init_req,
    input  logic reply_evt,
    input  logic dma_rel_evt,
    output logic mclk,
    output logic addr_strobe
);
    import mcg_pkg::*;

    localparam int MAX_LEN   = max3(max3(HI_CYC, STUT_CYC, LO_CYC),
                                    INIT_LO_CYC, RELOC_LO_CYC);
    localparam int CNT_W     = $clog2(MAX_LEN);
    localparam int HI_LAST   = HI_CYC - 1;
    localparam int STUT_LAST = STUT_CYC - 1;

    typedef struct packed {
        phase_t           phase;
        logic             mclk;
        logic [CNT_W-1:0] cnt;
        logic             reloc;
        logic             init;
        logic             strobe;
    } seq_t;

    seq_t q, d;

    logic             rel_done;
    logic [CNT_W-1:0] low_last;

    mcg_release_timer #(
        .REPLY_DLY (REPLY_DLY),
        .DMA_DLY   (DMA_DLY)
    ) rel_tmr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (q.phase == PH_STOP),
        .reply_evt   (reply_evt),
        .dma_rel_evt (dma_rel_evt),
        .done        (rel_done)
    );

    mcg_low_shape #(
        .LO_CYC       (LO_CYC),
        .INIT_LO_CYC  (INIT_LO_CYC),
        .RELOC_LO_CYC (RELOC_LO_CYC),
        .CNT_W        (CNT_W)
    ) low_shape_i (
        .reloc    (q.reloc),
        .init     (q.init),
        .last_idx (low_last)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        unique case (q.phase)
            PH_HIGH: begin
                if (q.cnt == CNT_W'(HI_LAST)) begin
                    if (hold_req) begin
                        d.phase = PH_STOP;
                    end else if (stretch_req) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else begin
                        d.phase = PH_LOW;
                        d.mclk  = 1'b0;
                        d.cnt   = '0;
                        d.reloc = reloc_req;
                        d.init  = 1'b0;
                    end
                end else if (q.cnt >= CNT_W'(STUT_LAST)) begin
                    d.phase = PH_LOW;
                    d.mclk  = 1'b0;
                    d.cnt   = '0;
                    d.reloc = reloc_req;
                    d.init  = 1'b0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            PH_STOP: begin
                if (rel_done) begin
                    d.phase = PH_LOW;
                    d.mclk  = 1'b0;
                    d.cnt   = '0;
                    d.reloc = reloc_req;
                    d.init  = 1'b0;
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.init = init_req;
                end
                if (q.cnt == low_last) begin
                    d.phase = PH_HIGH;
                    d.mclk  = 1'b1;
                    d.cnt   = '0;
                    d.reloc = 1'b0;
                    d.init  = 1'b0;
                end else begin
                    d.cnt    = q.cnt + CNT_W'(1);
                    d.strobe = q.reloc && (q.cnt == CNT_W'(STROBE_IDX - 1));
                end
            end
            default: begin
                d.phase = PH_HIGH;
                d.mclk  = 1'b1;
                d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase  <= PH_HIGH;
            q.mclk   <= 1'b1;
            q.cnt    <= '0;
            q.reloc  <= 1'b0;
            q.init   <= 1'b0;
            q.strobe <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mclk        = q.mclk;
    assign addr_strobe = q.strobe;
endmodule

// File: rtl/mcg_chk.sv
module mcg_chk (
    input logic clk,
    input logic rst_n,
    input logic mclk,
    input logic strobe,
    input logic rel_done
);
    // R1
    hi_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk) |=> mclk);

    // R1
    lo_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mclk) |=> !mclk);

    // R8
    strobe_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !mclk);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R8
    strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(mclk, 4) && !$past(mclk, 3)));

    // R4
    release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |=> !mclk);

    // R3
    release_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |-> mclk);
endmodule

bind microcycle_clkgen mcg_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclk     (mclk),
    .strobe   (addr_strobe),
    .rel_done (rel_done)
);

// File: tb/microcycle_clkgen_tb_top.sv
module microcycle_clkgen_tb_top;
    localparam int K = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stretch_req = 1'b0;
    logic hold_req = 1'b0;
    logic reloc_req = 1'b0;
    logic init_req = 1'b0;
    logic reply_evt = 1'b0;
    logic dma_rel_evt = 1'b0;
    logic mclk;
    logic addr_strobe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    microcycle_clkgen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stretch_req (stretch_req),
        .hold_req    (hold_req),
        .reloc_req   (reloc_req),
        .init_req    (init_req),
        .reply_evt   (reply_evt),
        .dma_rel_evt (dma_rel_evt),
        .mclk        (mclk),
        .addr_strobe (addr_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_evt(input bit on, input bit use_dma);
        reply_evt   = on && !use_dma;
        dma_rel_evt = on && use_dma;
    endtask

    // Entered at the first high sample of a microcycle; leaves at the next one.
    task automatic run_cycle(input bit st, input bit ho, input bit re, input bit ini,
                             input bit use_dma, output int hi, output int lo,
                             output int sb_cnt, output int sb_pos);
        stretch_req = st;
        hold_req    = ho;
        reloc_req   = re;
        init_req    = ini;
        hi = 1; lo = 0; sb_cnt = 0; sb_pos = 0;
        if (addr_strobe) sb_cnt++;
        while (1) begin
            // stray event in period 1 (R6), real plus repeat event at K and K+1
            set_evt((hi == 1) || (ho && (hi == K || hi == K + 1)), use_dma);
            @(negedge clk);
            set_evt(1'b0, use_dma);
            if (mclk) begin
                hi++;
                if (addr_strobe) sb_cnt++;
            end else begin
                break;
            end
        end
        lo = 1;
        if (addr_strobe) begin sb_cnt++; sb_pos = lo; end
        while (1) begin
            @(negedge clk);
            if (!mclk) begin
                lo++;
                if (addr_strobe) begin sb_cnt++; sb_pos = lo; end
            end else begin
                break;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, lo, sc, sp;
        int e_hi, e_lo;
        repeat (3) @(negedge clk);
        check("R1 reset mclk", int'(mclk), 1);
        check("R1 reset strobe", int'(addr_strobe), 0);
        rst_n = 1'b1;
        while (mclk !== 1'b0) @(negedge clk);
        while (mclk !== 1'b1) @(negedge clk);

        run_cycle(0, 0, 0, 0, 0, hi, lo, sc, sp);
        check("R1 normal high", hi, 2);
        check("R1 normal low", lo, 2);
        check("R8 normal strobe", sc, 0);

        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 32; c++) begin
                bit st, ho, re, ini, dm;
                st = c[0]; ho = c[1]; re = c[2]; ini = c[3]; dm = c[4];
                run_cycle(st, ho, re, ini, dm, hi, lo, sc, sp);
                if (ho) e_hi = K + (dm ? 2 : 3) + 1;
                else    e_hi = st ? 3 : 2;
                e_lo = re ? 5 : (ini ? 3 : 2);
                if (ho && !dm)     check("R4 reply release high", hi, e_hi);
                else if (ho && dm) check("R5 dma release high", hi, e_hi);
                else if (st)       check("R2 stretch high", hi, e_hi);
                else               check("R6 stray event high", hi, e_hi);
                if (ho && st)      check("R3 stop over stretch", hi, e_hi);
                if (re && ini)     check("R10 reloc over init low", lo, e_lo);
                else if (re)       check("R7 reloc low", lo, e_lo);
                else if (ini)      check("R9 init low", lo, e_lo);
                else               check("R1 plain low", lo, e_lo);
                check("R8 strobe count", sc, re ? 1 : 0);
                if (re) check("R8 strobe position", sp, 4);
            end
        end

        run_cycle(0, 0, 0, 0, 0, hi, lo, sc, sp);
        check("R1 final high", hi, 2);
        check("R1 final low", lo, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule